// File: doc/BRIEF.md
# Decoupled register access proxy

The proxy lets a host reach registers inside power-gated domains without keeping those domains awake itself. The host writes two registers: a data word and a command word. The command word holds a target offset, an operation code, a domain code and a go bit. Setting the go bit starts one transfer of a single 32-bit word. The engine then raises the wake request for the selected domain, or for all of them. It waits for every acknowledge it needs, issues one strobe on the shared register access port and then releases the wake request. When the transfer is complete, the engine clears the go bit.

For a write, the host fills the data word before it launches. For a read, the data word holds the fetched value once go reads back as zero. A wider access is made as consecutive single-word launches at increasing offsets. The host may first write the command fields with go clear and then launch with a second write. While go is set, the register pair is locked against host writes.

Top module: `dap_top`

## Requirements
- R1: After reset both host registers read as zero, no wake request is raised and no access strobe is issued.
- R2: The data word is at host offset 0xF00 and the command word at 0xF04. Both read back what was last stored in them. Any other offset reads zero.
- R3: Command word layout: bit 31 is go, bits [29:28] are the domain code, bits [27:24] are the operation code (0 = write, 1 = read) and bits [23:0] are the target offset. A write operation drives exactly one strobe with the write flag high, the target offset and the data word contents.
- R4: A read operation drives exactly one strobe with the write flag low. The word returned on the access port is stored into the data word before go clears.
- R5: Domain code 0 raises wake request bit 0, code 1 raises bit 1 and code 2 raises bit 2. No wake request is raised while the engine is idle.
- R6: Domain code 3 raises all wake requests and waits for every acknowledge before the access.
- R7: The access strobe is never issued unless every requested domain is acknowledging.
- R8: Hardware clears go after each launched command, and the wake requests are already low when go reads back zero.
- R9: A command word write with go clear only stores the fields. It causes no wake request and no access.
- R10: Host writes to either register while go is set are ignored.
- R11: An operation code other than 0 or 1 clears go without any wake request or access.
- R12: Each launch produces exactly one single-cycle strobe. Two launches at consecutive word offsets produce two separate transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_wr_i | input | 1 | Host register write strobe |
| host_addr_i | input | 12 | Host register offset |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Host read data for host_addr_i (combinational) |
| wake_req_o | output | 3 | Per-domain wake request |
| wake_ack_i | input | 3 | Per-domain wake acknowledge |
| acc_stb_o | output | 1 | Single-cycle register access strobe |
| acc_we_o | output | 1 | Access is a write |
| acc_off_o | output | 24 | Target register offset |
| acc_wdata_o | output | 32 | Access write data |
| acc_rdata_i | input | 32 | Access read data, sampled on the strobe cycle |

## Verification
A sequencer stuck outside idle shows at the ports in one of two ways: go never clears, or a wake request stays high after go has cleared. Either is seen within a few cycles of the expected completion. A wrong domain decode shows up at the strobe cycle as a wake vector that differs from the one the command selects. A broken busy lock shows up only on the first transfer after the blocked writes, as a wrong offset or wrong data on the strobe, or as a changed command readback. For that reason every launch is compared at its strobe against the command that was queued for it.

// File: rtl/dap_pkg.sv
package dap_pkg;
  localparam int unsigned DW      = 32;
  localparam int unsigned OFF_W   = 24;
  localparam int unsigned DOM_W   = 2;
  localparam int unsigned OP_W    = 4;
  localparam int unsigned GO_BIT  = 31;
  localparam int unsigned DOM_LSB = 28;
  localparam int unsigned OP_LSB  = 24;
  localparam logic [OP_W-1:0]  OP_WR   = 4'd0;
  localparam logic [OP_W-1:0]  OP_RD   = 4'd1;
  localparam logic [DOM_W-1:0] DOM_ALL = '1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAKE, ST_WAIT, ST_ACCESS, ST_RELEASE
  } dap_state_e;
endpackage

// File: rtl/dap_host_regs.sv
module dap_host_regs
  import dap_pkg::*;
#(
  parameter int unsigned HADDR_W   = 12,
  parameter logic [HADDR_W-1:0] DATA_ADDR = 12'hF00,
  parameter logic [HADDR_W-1:0] CTRL_ADDR = 12'hF04
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [HADDR_W-1:0] addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  input  logic               cap_i,
  input  logic [DW-1:0]      cap_data_i,
  input  logic               clr_go_i,
  output logic               go_o,
  output logic [OP_W-1:0]    op_o,
  output logic [DOM_W-1:0]   dom_o,
  output logic [OFF_W-1:0]   off_o,
  output logic [DW-1:0]      data_o
);
  logic [DW-2:0] ctrl_q;
  logic          go_q;
  logic [DW-1:0] data_q;
  logic          wr_ctrl, wr_data;

  // the pair is locked while an access is in flight
  assign wr_ctrl = wr_i && (addr_i == CTRL_ADDR) && !go_q;
  assign wr_data = wr_i && (addr_i == DATA_ADDR) && !go_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      go_q   <= 1'b0;
    end else if (clr_go_i) begin
      go_q <= 1'b0;
    end else if (wr_ctrl) begin
      ctrl_q <= wdata_i[DW-2:0];
      go_q   <= wdata_i[GO_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (cap_i)   data_q <= cap_data_i;
    else if (wr_data) data_q <= wdata_i;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == DATA_ADDR)      rdata_o = data_q;
    else if (addr_i == CTRL_ADDR) rdata_o = {go_q, ctrl_q};
  end

  assign go_o   = go_q;
  assign op_o   = ctrl_q[OP_LSB +: OP_W];
  assign dom_o  = ctrl_q[DOM_LSB +: DOM_W];
  assign off_o  = ctrl_q[OFF_W-1:0];
  assign data_o = data_q;

  p_busy_lock_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_q && !clr_go_i && !cap_i) |=> (go_q && $stable(ctrl_q) && $stable(data_q)));
  p_go_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_go_i |=> !go_q);
  p_stage_only_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!go_q && wr_i && addr_i == CTRL_ADDR && !wdata_i[GO_BIT]) |=> !go_q);
endmodule

// File: rtl/dap_wake_decode.sv
module dap_wake_decode
  import dap_pkg::*;
#(
  parameter int unsigned N_DOM = 3
) (
  input  logic [DOM_W-1:0] dom_i,
  input  logic [N_DOM-1:0] ack_i,
  output logic [N_DOM-1:0] mask_o,
  output logic             ack_ok_o
);
  logic [N_DOM-1:0] sat;

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    assign mask_o[d] = (dom_i == DOM_ALL) || (dom_i == DOM_W'(d));
    assign sat[d]    = !mask_o[d] || ack_i[d];
  end

  assign ack_ok_o = &sat;
endmodule

// File: rtl/dap_seq.sv
module dap_seq
  import dap_pkg::*;
#(
  parameter int unsigned N_DOM = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic [N_DOM-1:0] mask_i,
  input  logic             ack_ok_i,
  output logic [N_DOM-1:0] wake_req_o,
  output logic             acc_stb_o,
  output logic             acc_we_o,
  output logic             cap_o,
  output logic             clr_go_o
);
  dap_state_e state_q, state_d;
  logic op_ok, holding;

  assign op_ok = (op_i == OP_WR) || (op_i == OP_RD);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (go_i) state_d = op_ok ? ST_WAKE : ST_RELEASE;
      ST_WAKE:    state_d = ST_WAIT;
      ST_WAIT:    if (ack_ok_i) state_d = ST_ACCESS;
      ST_ACCESS:  state_d = ST_RELEASE;
      ST_RELEASE: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign holding    = (state_q == ST_WAKE) || (state_q == ST_WAIT) || (state_q == ST_ACCESS);
  assign wake_req_o = holding ? mask_i : '0;
  assign acc_stb_o  = (state_q == ST_ACCESS);
  assign acc_we_o   = (op_i == OP_WR);
  assign cap_o      = acc_stb_o && (op_i == OP_RD);
  assign clr_go_o   = (state_q == ST_RELEASE);

  p_idle_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (wake_req_o == '0 && !acc_stb_o));
  p_single_stb_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_stb_o |=> !acc_stb_o);
  p_bad_op_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && go_i && !op_ok) |=> (wake_req_o == '0 && !acc_stb_o));
endmodule

// File: rtl/dap_top.sv
module dap_top
  import dap_pkg::*;
#(
  parameter int unsigned HADDR_W = 12,
  parameter int unsigned N_DOM   = 3,
  parameter logic [HADDR_W-1:0] DATA_ADDR = 12'hF00,
  parameter logic [HADDR_W-1:0] CTRL_ADDR = 12'hF04
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               host_wr_i,
  input  logic [HADDR_W-1:0] host_addr_i,
  input  logic [DW-1:0]      host_wdata_i,
  output logic [DW-1:0]      host_rdata_o,
  output logic [N_DOM-1:0]   wake_req_o,
  input  logic [N_DOM-1:0]   wake_ack_i,
  output logic               acc_stb_o,
  output logic               acc_we_o,
  output logic [OFF_W-1:0]   acc_off_o,
  output logic [DW-1:0]      acc_wdata_o,
  input  logic [DW-1:0]      acc_rdata_i
);
  logic             go, cap, clr_go, ack_ok;
  logic [OP_W-1:0]  op;
  logic [DOM_W-1:0] dom;
  logic [N_DOM-1:0] mask;

  dap_host_regs #(
    .HADDR_W(HADDR_W), .DATA_ADDR(DATA_ADDR), .CTRL_ADDR(CTRL_ADDR)
  ) u_regs (
    .clk_i, .rst_ni,
    .wr_i(host_wr_i), .addr_i(host_addr_i), .wdata_i(host_wdata_i),
    .rdata_o(host_rdata_o),
    .cap_i(cap), .cap_data_i(acc_rdata_i), .clr_go_i(clr_go),
    .go_o(go), .op_o(op), .dom_o(dom), .off_o(acc_off_o), .data_o(acc_wdata_o)
  );

  dap_wake_decode #(.N_DOM(N_DOM)) u_dec (
    .dom_i(dom), .ack_i(wake_ack_i), .mask_o(mask), .ack_ok_o(ack_ok)
  );

  dap_seq #(.N_DOM(N_DOM)) u_seq (
    .clk_i, .rst_ni,
    .go_i(go), .op_i(op), .mask_i(mask), .ack_ok_i(ack_ok),
    .wake_req_o(wake_req_o), .acc_stb_o(acc_stb_o), .acc_we_o(acc_we_o),
    .cap_o(cap), .clr_go_o(clr_go)
  );

  p_stb_acked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_stb_o |-> (wake_req_o != '0 && (wake_ack_i & wake_req_o) == wake_req_o));
  p_stb_under_go_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_stb_o |-> go);
endmodule

// File: tb/dap_top_test.sv
module dap_top_test;
  import dap_pkg::*;

  localparam logic [11:0] A_DATA = 12'hF00;
  localparam logic [11:0] A_CTRL = 12'hF04;

  typedef struct packed {
    logic        we;
    logic [23:0] off;
    logic [31:0] wd;
    logic [2:0]  mask;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [11:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic [2:0]  wake_req, wake_ack;
  logic        acc_stb, acc_we;
  logic [23:0] acc_off;
  logic [31:0] acc_wdata, acc_rdata;

  logic [31:0] mem [64];
  int unsigned lat [3];
  int unsigned cnt [3];
  int total = 0, bad = 0, stb_cnt = 0, wake_seen = 0, cycles = 0;
  exp_t q[$];

  always #2 clk = ~clk;

  dap_top uut (
    .clk_i(clk), .rst_ni(rst_n),
    .host_wr_i(host_wr), .host_addr_i(host_addr), .host_wdata_i(host_wdata),
    .host_rdata_o(host_rdata),
    .wake_req_o(wake_req), .wake_ack_i(wake_ack),
    .acc_stb_o(acc_stb), .acc_we_o(acc_we), .acc_off_o(acc_off),
    .acc_wdata_o(acc_wdata), .acc_rdata_i(acc_rdata)
  );

  // domain model: ack follows request after lat cycles, drops with it
  for (genvar d = 0; d < 3; d++) begin : g_ack
    always @(posedge clk) begin
      if (!wake_req[d]) cnt[d] <= 0;
      else if (cnt[d] < 30) cnt[d] <= cnt[d] + 1;
    end
    assign wake_ack[d] = wake_req[d] && (cnt[d] >= lat[d]);
  end

  assign acc_rdata = mem[acc_off[5:0]];

  always @(posedge clk) if (acc_stb && acc_we) mem[acc_off[5:0]] <= acc_wdata;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor: every strobe must match the oldest queued command
  always @(negedge clk) begin
    if (rst_n) begin
      if (wake_req != 3'b000) wake_seen++;
      if (acc_stb) begin
        stb_cnt++;
        if (q.size() == 0) begin
          chk(1'b0, "R12 unexpected strobe", {8'h0, acc_off}, 32'h0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(acc_we == e.we, "R3/R4 op", {31'h0, acc_we}, {31'h0, e.we});
          chk(acc_off == e.off, "R3 offset", {8'h0, acc_off}, {8'h0, e.off});
          if (e.we) chk(acc_wdata == e.wd, "R3 wdata", acc_wdata, e.wd);
          chk(wake_req == e.mask, "R5/R6 wake mask", {29'h0, wake_req}, {29'h0, e.mask});
          chk((wake_ack & wake_req) == wake_req, "R7 acks at strobe",
              {29'h0, wake_ack}, {29'h0, wake_req});
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      chk(1'b0, "watchdog", cycles, 50000);
      report();
    end
  end

  task automatic hwrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] c;
    int n = 0;
    do begin
      hread(A_CTRL, c);
      n++;
    end while (c[31] && n < 200);
    chk(!c[31], {tag, " go clears"}, c, {1'b0, c[30:0]});
    chk(wake_req == 3'b000, {tag, " wake low at done"}, {29'h0, wake_req}, 32'h0);
  endtask

  function automatic logic [31:0] cmd(input bit go, input logic [1:0] dm,
                                      input logic [3:0] op, input logic [23:0] off);
    return {go, 1'b0, dm, op, off};
  endfunction

  function automatic logic [2:0] mask_of(input logic [1:0] dm);
    return (dm == 2'd3) ? 3'b111 : (3'b001 << dm);
  endfunction

  task automatic do_write(input logic [1:0] dm, input logic [23:0] off,
                          input logic [31:0] d, input string tag);
    int s0 = stb_cnt;
    hwrite(A_DATA, d);
    q.push_back('{we: 1'b1, off: off, wd: d, mask: mask_of(dm)});
    hwrite(A_CTRL, cmd(1'b1, dm, OP_WR, off));
    wait_idle(tag);
    chk(stb_cnt == s0 + 1, {tag, " one strobe"}, stb_cnt, s0 + 1);
    chk(mem[off[5:0]] == d, {tag, " landed"}, mem[off[5:0]], d);
  endtask

  task automatic do_read(input logic [1:0] dm, input logic [23:0] off,
                         input bit stage, input string tag);
    logic [31:0] expv, got;
    int s0 = stb_cnt;
    expv = mem[off[5:0]];
    q.push_back('{we: 1'b0, off: off, wd: 32'h0, mask: mask_of(dm)});
    if (stage) hwrite(A_CTRL, cmd(1'b0, dm, OP_RD, off));
    hwrite(A_CTRL, cmd(1'b1, dm, OP_RD, off));
    wait_idle(tag);
    hread(A_DATA, got);
    chk(got == expv, {tag, " data"}, got, expv);
    chk(stb_cnt == s0 + 1, {tag, " one strobe"}, stb_cnt, s0 + 1);
  endtask

  initial begin
    logic [31:0] v;
    int s0, w0;
    for (int i = 0; i < 64; i++) mem[i] = 32'h1000 + i * 32'h0101_0101;
    lat[0] = 1; lat[1] = 2; lat[2] = 3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    hread(A_DATA, v); chk(v == 0, "R1 data reset", v, 0);
    hread(A_CTRL, v); chk(v == 0, "R1 ctrl reset", v, 0);
    chk(wake_req == 0 && !acc_stb, "R1 quiet", {28'h0, acc_stb, wake_req}, 0);

    // R2 decode and readback, R9 staging does not launch
    hwrite(A_DATA, 32'h1234_5678);
    hread(A_DATA, v); chk(v == 32'h1234_5678, "R2 data readback", v, 32'h1234_5678);
    s0 = stb_cnt; w0 = wake_seen;
    hwrite(A_CTRL, cmd(1'b0, 2'd2, OP_RD, 24'h00_0030));
    repeat (5) @(negedge clk);
    hread(A_CTRL, v); chk(v == cmd(1'b0, 2'd2, OP_RD, 24'h30), "R2 ctrl readback", v, cmd(1'b0, 2'd2, OP_RD, 24'h30));
    hread(12'hF08, v); chk(v == 0, "R2 unmapped reads zero", v, 0);
    chk(stb_cnt == s0 && wake_seen == w0, "R9 staging no access", stb_cnt, s0);

    // R3 writes to each domain, R5 masks
    do_write(2'd0, 24'h00_0004, 32'hA0A0_0001, "R3 blit write");
    do_write(2'd1, 24'h00_0008, 32'hB1B1_0002, "R3 render write");
    do_write(2'd2, 24'h12_340C, 32'hC2C2_0003, "R5 media write");

    // R4 reads, with and without staging
    do_read(2'd1, 24'h00_0008, 1'b1, "R4 staged read");
    do_read(2'd0, 24'h00_0011, 1'b0, "R4 direct read");

    // R6 all domains, skewed acks
    lat[0] = 6; lat[1] = 1; lat[2] = 9;
    do_write(2'd3, 24'h00_0018, 32'hD3D3_0004, "R6 all write");
    do_read(2'd3, 24'h00_0018, 1'b0, "R6 all read");

    // R12 two consecutive dwords
    lat[0] = 1; lat[1] = 1; lat[2] = 1;
    do_write(2'd1, 24'h00_0020, 32'h0000_AAAA, "R12 low dword");
    do_write(2'd1, 24'h00_0024, 32'h0000_BBBB, "R12 high dword");
    do_read(2'd1, 24'h00_0020, 1'b0, "R12 read low");
    do_read(2'd1, 24'h00_0024, 1'b0, "R12 read high");

    // R10 writes while busy are ignored
    lat[1] = 12;
    s0 = stb_cnt;
    hwrite(A_DATA, 32'hCAFE_0001);
    q.push_back('{we: 1'b1, off: 24'h00_0028, wd: 32'hCAFE_0001, mask: 3'b010});
    hwrite(A_CTRL, cmd(1'b1, 2'd1, OP_WR, 24'h28));
    hwrite(A_DATA, 32'hDEAD_BEEF);
    hwrite(A_CTRL, cmd(1'b1, 2'd0, OP_RD, 24'h2C));
    wait_idle("R10 busy");
    repeat (6) @(negedge clk);
    chk(stb_cnt == s0 + 1, "R10 no extra access", stb_cnt, s0 + 1);
    hread(A_CTRL, v); chk(v == cmd(1'b0, 2'd1, OP_WR, 24'h28), "R10 ctrl kept", v, cmd(1'b0, 2'd1, OP_WR, 24'h28));
    hread(A_DATA, v); chk(v == 32'hCAFE_0001, "R10 data kept", v, 32'hCAFE_0001);
    chk(mem[6'h28] == 32'hCAFE_0001, "R10 target written", mem[6'h28], 32'hCAFE_0001);
    chk(mem[6'h2C] == 32'h1000 + 32'h2C * 32'h0101_0101, "R10 other untouched", mem[6'h2C], 32'h1000 + 32'h2C * 32'h0101_0101);
    lat[1] = 1;

    // R11 undefined opcode
    s0 = stb_cnt; w0 = wake_seen;
    hwrite(A_CTRL, cmd(1'b1, 2'd3, 4'd5, 24'h30));
    wait_idle("R11 bad op");
    chk(stb_cnt == s0, "R11 no strobe", stb_cnt, s0);
    chk(wake_seen == w0, "R11 no wake", wake_seen, w0);

    // R8 machine still usable after bad op
    do_write(2'd2, 24'h00_0034, 32'h5555_AAAA, "R8 after bad op");

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R12 all queued accesses seen", q.size(), 0);
    report();
  end
endmodule